// File: doc/BRIEF.md
# Banked Cartridge Memory Controller

This block sits between an 8-bit processor bus with a 16-bit address and the ROM and battery-less RAM of a plug-in cartridge. The processor cannot write the ROM, so any write that lands in the lower half of the address map is treated as a control-register write. A register chosen by address bits 15:13 takes the byte. These registers hold a 7-bit ROM page number, a 2-bit RAM page number, a RAM gate and a banking mode. Reads and RAM writes are translated on the same cycle into a flat ROM address or RAM address, with chip selects and a RAM write enable. The block also returns the byte the processor sees, after substituting zeros or an open-bus value where no device answers.

The ROM page number is split in two. Its low five bits come from one register. Its upper two bits share a field with the RAM page number, and a mode bit decides which of the two receives that field. When the mode changes, the two bits move from one page number to the other. The number of ROM pages, the number of RAM pages and whether RAM is fitted at all are parameters. The memory arrays sit outside the block.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A write to 0x0000-0x1FFF opens the RAM gate when the byte is exactly 0x0A and closes it for any other byte. No other write changes the gate.
- R2: A write to 0x2000-0x3FFF loads data bits 4:0 into ROM page bits 4:0 and leaves ROM page bits 6:5 unchanged.
- R3: If the ROM page low five bits would become zero, bit 0 is set instead. So pages 0x00, 0x20, 0x40 and 0x60 are never selected; 0x01, 0x21, 0x41 and 0x61 are selected in their place.
- R4: A write to 0x4000-0x5FFF takes data bits 1:0. In RAM-banking mode they become the RAM page. In ROM-banking mode they become ROM page bits 6:5.
- R5: A write to 0x6000-0x7FFF sets the mode from data bit 0 (0 = ROM banking, 1 = RAM banking). Entering RAM banking moves ROM page bits 6:5 into the RAM page and clears them. Leaving it moves the RAM page back into ROM page bits 6:5 and zeroes the RAM page. A write that leaves the mode unchanged moves nothing.
- R6: After reset the ROM page is 1, the RAM page is 0, the mode is ROM banking and the RAM gate is closed.
- R7: Reads of 0x0000-0x3FFF assert the ROM select with ROM address = CPU address bits 13:0 (page 0) and return the ROM byte.
- R8: Reads of 0x4000-0x7FFF use ROM address = page × 0x4000 + (address − 0x4000), with the page in ROM address bits 20:14.
- R9: Accesses to 0xA000-0xBFFF use RAM address = RAM page × 0x2000 + (address − 0xA000), with the page in RAM address bits 14:13. A write in this window asserts the RAM write enable, and a read returns the RAM byte.
- R10: A ROM page at or above the ROM page count, or a RAM page at or above the RAM page count, reads as 0x00 with no select asserted. Writes to such a RAM page are dropped.
- R11: With no RAM fitted, the RAM window reads as 0x00 and never asserts a RAM select.
- R12: With RAM fitted and the gate closed, the RAM window reads as 0xFF and writes there are dropped.
- R13: Addresses 0x8000-0x9FFF and 0xC000-0xFFFF read as 0xFF, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_rd | input | 1 | Read strobe |
| cpu_rdata | output | 8 | Byte returned to the processor |
| rom_addr | output | 21 | Flat ROM address |
| rom_cs | output | 1 | ROM select |
| rom_rdata | input | 8 | ROM byte |
| ram_addr | output | 15 | Flat RAM address |
| ram_cs | output | 1 | RAM select |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM byte |

## Verification
Every control register feeds the combinational read path directly, so a wrong page number shows up in the next cycle after the write. It appears as a different ROM or RAM address and a different returned byte. The ROM model returns a byte built from the page number, which makes a misplaced bank bit visible in one read. A wrong mode transfer first shows up after the mode switch: the ROM page keeps stale upper bits or the RAM page points elsewhere. Reading back a RAM location written in a known page exposes it. A gate or range error shows as 0x00 or 0xFF where memory data was expected, or as a select or write enable that should have stayed low.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

    // Fixed processor address map geometry
    localparam int CPU_AW      = 16;
    localparam int ROM_PAGE_AW = 14;   // 16 KiB ROM window
    localparam int RAM_PAGE_AW = 13;   // 8 KiB RAM window

    localparam logic [7:0] RAM_GATE_KEY = 8'h0A;
    localparam logic [7:0] OPEN_BUS     = 8'hFF;
    localparam logic [7:0] EMPTY_BYTE   = 8'h00;

    typedef enum logic [0:0] {
        MODE_ROM_BANKING = 1'b0,
        MODE_RAM_BANKING = 1'b1
    } bank_mode_e;

    typedef enum logic [2:0] {
        SEL_RAM_GATE,
        SEL_BANK_LO,
        SEL_BANK_HI,
        SEL_MODE,
        SEL_NONE
    } ctrl_sel_e;

    typedef enum logic [1:0] {
        WIN_ROM_FIXED,
        WIN_ROM_BANKED,
        WIN_RAM,
        WIN_NONE
    } window_e;

    // Control register targeted by a write, from address bits 15:13
    function automatic ctrl_sel_e decode_ctrl(input logic [2:0] top);
        ctrl_sel_e s;
        case (top)
            3'd0:    s = SEL_RAM_GATE;
            3'd1:    s = SEL_BANK_LO;
            3'd2:    s = SEL_BANK_HI;
            3'd3:    s = SEL_MODE;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

    // Memory window of an access, from address bits 15:13
    function automatic window_e decode_window(input logic [2:0] top);
        window_e w;
        case (top)
            3'd0, 3'd1: w = WIN_ROM_FIXED;
            3'd2, 3'd3: w = WIN_ROM_BANKED;
            3'd5:       w = WIN_RAM;
            default:    w = WIN_NONE;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
    import cart_bank_pkg::*;
#(
    parameter int LO_W = 5,
    parameter int HI_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  ctrl_sel_e              sel,
    input  logic [7:0]             wdata,
    output logic [LO_W+HI_W-1:0]   rom_bank,
    output logic [HI_W-1:0]        ram_bank,
    output logic                   ram_gate,
    output bank_mode_e             mode
);

    typedef struct packed {
        logic [HI_W-1:0] rom_hi;
        logic [LO_W-1:0] rom_lo;
        logic [HI_W-1:0] ram_pg;
        bank_mode_e      mode;
        logic            gate;
    } bank_state_t;

    localparam bank_state_t RESET_STATE = '{
        rom_hi: '0,
        rom_lo: LO_W'(1),
        ram_pg: '0,
        mode:   MODE_ROM_BANKING,
        gate:   1'b0
    };

    bank_state_t st_d, st_q;
    bank_mode_e  req_mode;

    always_comb begin
        st_d     = st_q;
        req_mode = bank_mode_e'(wdata[0]);
        if (wr_en) begin
            case (sel)
                SEL_RAM_GATE: begin
                    st_d.gate = (wdata == RAM_GATE_KEY);
                end
                SEL_BANK_LO: begin
                    st_d.rom_lo = wdata[LO_W-1:0];
                    if (st_d.rom_lo == '0) begin
                        st_d.rom_lo = LO_W'(1);
                    end
                end
                SEL_BANK_HI: begin
                    if (st_q.mode == MODE_RAM_BANKING) begin
                        st_d.ram_pg = wdata[HI_W-1:0];
                    end else begin
                        st_d.rom_hi = wdata[HI_W-1:0];
                    end
                end
                SEL_MODE: begin
                    if (req_mode != st_q.mode) begin
                        st_d.mode = req_mode;
                        if (req_mode == MODE_RAM_BANKING) begin
                            st_d.ram_pg = st_q.rom_hi;
                            st_d.rom_hi = '0;
                        end else begin
                            st_d.rom_hi = st_q.ram_pg;
                            st_d.ram_pg = '0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= RESET_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign rom_bank = {st_q.rom_hi, st_q.rom_lo};
    assign ram_bank = st_q.ram_pg;
    assign ram_gate = st_q.gate;
    assign mode     = st_q.mode;

    // Assertions guarding the register file

    AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel == SEL_RAM_GATE) |=> $stable(st_q.gate)); // R1

    AST_GATE_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_RAM_GATE && wdata == RAM_GATE_KEY) |=> st_q.gate); // R1

    AST_HI_KEPT_ON_LO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_BANK_LO) |=> $stable(st_q.rom_hi)); // R2

    AST_LO_ZERO_REMAP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_BANK_LO && wdata[LO_W-1:0] == '0) |=> st_q.rom_lo == LO_W'(1)); // R3

    AST_RAM_MODE_HI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_RAM_BANKING) |-> st_q.rom_hi == '0); // R5

    AST_ROM_MODE_RAMPG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_ROM_BANKING) |-> st_q.ram_pg == '0); // R5

    AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel == SEL_MODE) |=> $stable(st_q.mode)); // R5

endmodule

// File: rtl/cart_bank_map.sv
module cart_bank_map
    import cart_bank_pkg::*;
#(
    parameter int LO_W       = 5,
    parameter int HI_W       = 2,
    parameter int ROM_BANKS  = 64,
    parameter int RAM_BANKS  = 2,
    parameter bit RAM_FITTED = 1'b1
) (
    input  logic [CPU_AW-1:0]                  cpu_addr,
    input  logic                               cpu_rd,
    input  logic                               cpu_wr,
    input  logic [LO_W+HI_W-1:0]               rom_bank,
    input  logic [HI_W-1:0]                    ram_bank,
    input  logic                               ram_gate,
    input  logic [7:0]                         rom_rdata,
    input  logic [7:0]                         ram_rdata,
    output logic [ROM_PAGE_AW+LO_W+HI_W-1:0]   rom_addr,
    output logic                               rom_cs,
    output logic [RAM_PAGE_AW+HI_W-1:0]        ram_addr,
    output logic                               ram_cs,
    output logic                               ram_we,
    output logic [7:0]                         rdata
);

    localparam int BANK_W = LO_W + HI_W;
    localparam logic [BANK_W:0] ROM_LIMIT = (BANK_W+1)'(ROM_BANKS);

    window_e win;
    logic    rom_page_ok;
    logic    ram_present;
    logic    ram_page_ok;

    assign win         = decode_window(cpu_addr[CPU_AW-1:CPU_AW-3]);
    assign rom_page_ok = ({1'b0, rom_bank} < ROM_LIMIT);

    if (RAM_FITTED) begin : g_ram
        localparam logic [HI_W:0] RAM_LIMIT = (HI_W+1)'(RAM_BANKS);
        assign ram_present = 1'b1;
        assign ram_page_ok = ({1'b0, ram_bank} < RAM_LIMIT);
    end else begin : g_no_ram
        assign ram_present = 1'b0;
        assign ram_page_ok = 1'b0;
    end

    always_comb begin
        rom_addr = {{BANK_W{1'b0}}, cpu_addr[ROM_PAGE_AW-1:0]};
        rom_cs   = 1'b0;
        ram_addr = {ram_bank, cpu_addr[RAM_PAGE_AW-1:0]};
        ram_cs   = 1'b0;
        ram_we   = 1'b0;
        rdata    = OPEN_BUS;
        case (win)
            WIN_ROM_FIXED: begin
                rom_cs = cpu_rd;
                rdata  = rom_rdata;
            end
            WIN_ROM_BANKED: begin
                rom_addr = {rom_bank, cpu_addr[ROM_PAGE_AW-1:0]};
                if (rom_page_ok) begin
                    rom_cs = cpu_rd;
                    rdata  = rom_rdata;
                end else begin
                    rdata  = EMPTY_BYTE;
                end
            end
            WIN_RAM: begin
                if (!ram_present) begin
                    rdata = EMPTY_BYTE;
                end else if (!ram_gate) begin
                    rdata = OPEN_BUS;
                end else if (!ram_page_ok) begin
                    rdata = EMPTY_BYTE;
                end else begin
                    ram_cs = cpu_rd | cpu_wr;
                    ram_we = cpu_wr;
                    rdata  = ram_rdata;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cart_bank_pkg::*;
#(
    parameter int ROM_LO_BITS = 5,
    parameter int ROM_HI_BITS = 2,
    parameter int ROM_BANKS   = 64,
    parameter int RAM_BANKS   = 2,
    parameter bit RAM_FITTED  = 1'b1
) (
    input  logic                                           clk,
    input  logic                                           rst_n,
    input  logic [15:0]                                    cpu_addr,
    input  logic [7:0]                                     cpu_wdata,
    input  logic                                           cpu_wr,
    input  logic                                           cpu_rd,
    output logic [7:0]                                     cpu_rdata,
    output logic [ROM_PAGE_AW+ROM_LO_BITS+ROM_HI_BITS-1:0] rom_addr,
    output logic                                           rom_cs,
    input  logic [7:0]                                     rom_rdata,
    output logic [RAM_PAGE_AW+ROM_HI_BITS-1:0]             ram_addr,
    output logic                                           ram_cs,
    output logic                                           ram_we,
    output logic [7:0]                                     ram_wdata,
    input  logic [7:0]                                     ram_rdata
);

    localparam int BANK_W = ROM_LO_BITS + ROM_HI_BITS;
    localparam int ROM_AW = ROM_PAGE_AW + BANK_W;
    localparam int RAM_AW = RAM_PAGE_AW + ROM_HI_BITS;
    localparam logic [BANK_W:0]      ROM_LIMIT = (BANK_W+1)'(ROM_BANKS);
    localparam logic [ROM_HI_BITS:0] RAM_LIMIT = (ROM_HI_BITS+1)'(RAM_BANKS);

    ctrl_sel_e               ctrl_sel;
    logic [BANK_W-1:0]       rom_bank;
    logic [ROM_HI_BITS-1:0]  ram_bank;
    logic                    ram_gate;
    bank_mode_e              mode;

    assign ctrl_sel  = decode_ctrl(cpu_addr[15:13]);
    assign ram_wdata = cpu_wdata;

    cart_bank_regs #(
        .LO_W (ROM_LO_BITS),
        .HI_W (ROM_HI_BITS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cpu_wr),
        .sel      (ctrl_sel),
        .wdata    (cpu_wdata),
        .rom_bank (rom_bank),
        .ram_bank (ram_bank),
        .ram_gate (ram_gate),
        .mode     (mode)
    );

    cart_bank_map #(
        .LO_W       (ROM_LO_BITS),
        .HI_W       (ROM_HI_BITS),
        .ROM_BANKS  (ROM_BANKS),
        .RAM_BANKS  (RAM_BANKS),
        .RAM_FITTED (RAM_FITTED)
    ) u_map (
        .cpu_addr  (cpu_addr),
        .cpu_rd    (cpu_rd),
        .cpu_wr    (cpu_wr),
        .rom_bank  (rom_bank),
        .ram_bank  (ram_bank),
        .ram_gate  (ram_gate),
        .rom_rdata (rom_rdata),
        .ram_rdata (ram_rdata),
        .rom_addr  (rom_addr),
        .rom_cs    (rom_cs),
        .ram_addr  (ram_addr),
        .ram_cs    (ram_cs),
        .ram_we    (ram_we),
        .rdata     (cpu_rdata)
    );

    // Assertions on the translated outputs

    AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_cs && ram_cs)); // R9

    AST_WE_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_gate && cpu_wr)); // R12

    AST_WE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (cpu_addr[15:13] == 3'b101)); // R9

    AST_ROM_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rom_cs |-> ({1'b0, rom_addr[ROM_AW-1:ROM_PAGE_AW]} < ROM_LIMIT)); // R10

    AST_RAM_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_cs |-> ({1'b0, ram_addr[RAM_AW-1:RAM_PAGE_AW]} < RAM_LIMIT)); // R10

    AST_NO_RAM_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !RAM_FITTED |-> !ram_cs); // R11

    AST_UNMAPPED_OPEN_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] == 3'b100 || cpu_addr[15:14] == 2'b11) |-> (cpu_rdata == 8'hFF && !rom_cs && !ram_cs)); // R13

endmodule

// File: tb/cart_bank_ctrl_tb.sv
`timescale 1ns/1ps
module cart_bank_ctrl_tb;

    localparam real HALF = 4.0;   // 125 MHz
    localparam int  NV   = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  cpu_rdata, rom_rdata, ram_rdata, ram_wdata;
    logic [20:0] rom_addr;
    logic        rom_cs, ram_cs, ram_we;
    logic [14:0] ram_addr;

    logic [7:0]  nr_rdata, nr_rom_rdata, nr_ram_wdata;
    logic [20:0] nr_rom_addr;
    logic [14:0] nr_ram_addr;
    logic        nr_rom_cs, nr_ram_cs, nr_ram_we;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] ram_mem [64];

    always #(HALF) clk = ~clk;

    // ROM byte = {1, page} xor low address byte
    function automatic logic [7:0] rom_model(input logic [20:0] a);
        return {1'b1, a[20:14]} ^ a[7:0];
    endfunction

    assign rom_rdata    = rom_model(rom_addr);
    assign nr_rom_rdata = rom_model(nr_rom_addr);
    assign ram_rdata    = ram_mem[{ram_addr[14:13], ram_addr[3:0]}];

    always @(posedge clk) begin
        if (ram_we) ram_mem[{ram_addr[14:13], ram_addr[3:0]}] <= ram_wdata;
    end

    cart_bank_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
        .rom_addr(rom_addr), .rom_cs(rom_cs), .rom_rdata(rom_rdata),
        .ram_addr(ram_addr), .ram_cs(ram_cs), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    cart_bank_ctrl #(.RAM_FITTED(1'b0)) u_dut_noram (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(nr_rdata),
        .rom_addr(nr_rom_addr), .rom_cs(nr_rom_cs), .rom_rdata(nr_rom_rdata),
        .ram_addr(nr_ram_addr), .ram_cs(nr_ram_cs), .ram_we(nr_ram_we),
        .ram_wdata(nr_ram_wdata), .ram_rdata(8'h00)
    );

    // {is_write, req, addr, data, expected read byte}
    localparam logic [36:0] VEC [NV] = '{
        {1'b0, 4'd6,  16'h4000, 8'h00, 8'h81},  // R6 reset page 1
        {1'b1, 4'd2,  16'h2000, 8'h05, 8'h00},
        {1'b0, 4'd2,  16'h4000, 8'h00, 8'h85},  // R2
        {1'b0, 4'd8,  16'h4003, 8'h00, 8'h86},  // R8
        {1'b1, 4'd3,  16'h2100, 8'h00, 8'h00},
        {1'b0, 4'd3,  16'h4000, 8'h00, 8'h81},  // R3 zero -> 1
        {1'b1, 4'd2,  16'h2000, 8'h25, 8'h00},
        {1'b0, 4'd2,  16'h4000, 8'h00, 8'h85},  // R2 bits 7:5 of data ignored
        {1'b1, 4'd4,  16'h4000, 8'h01, 8'h00},
        {1'b0, 4'd4,  16'h4000, 8'h00, 8'hA5},  // R4 ROM mode steering
        {1'b1, 4'd3,  16'h2000, 8'h00, 8'h00},
        {1'b0, 4'd3,  16'h4000, 8'h00, 8'hA1},  // R3 0x20 -> 0x21
        {1'b1, 4'd4,  16'h4000, 8'h02, 8'h00},
        {1'b0, 4'd10, 16'h4000, 8'h00, 8'h00},  // R10 page 0x41 beyond count
        {1'b0, 4'd7,  16'h0010, 8'h00, 8'h90},  // R7
        {1'b0, 4'd7,  16'h3FFF, 8'h00, 8'h7F},  // R7
        {1'b1, 4'd4,  16'h4000, 8'h01, 8'h00},
        {1'b1, 4'd5,  16'h6000, 8'h01, 8'h00},
        {1'b0, 4'd5,  16'h4000, 8'h00, 8'h81},  // R5 hi bits cleared
        {1'b0, 4'd12, 16'hA002, 8'h00, 8'hFF},  // R12 gate closed
        {1'b1, 4'd1,  16'h0000, 8'h0A, 8'h00},
        {1'b1, 4'd9,  16'hA002, 8'h5C, 8'h00},
        {1'b0, 4'd9,  16'hA002, 8'h00, 8'h5C},  // R9 page 1
        {1'b1, 4'd4,  16'h4000, 8'h00, 8'h00},
        {1'b0, 4'd4,  16'hA002, 8'h00, 8'hEE},  // R4 RAM page 0 untouched
        {1'b1, 4'd9,  16'hA002, 8'h33, 8'h00},
        {1'b0, 4'd9,  16'hA002, 8'h00, 8'h33},  // R9
        {1'b1, 4'd4,  16'h4000, 8'h01, 8'h00},
        {1'b0, 4'd4,  16'hA002, 8'h00, 8'h5C},  // R4 RAM page 1 again
        {1'b0, 4'd4,  16'h4000, 8'h00, 8'h81},  // R4 ROM page unaffected
        {1'b1, 4'd5,  16'h6000, 8'h00, 8'h00},
        {1'b0, 4'd5,  16'h4000, 8'h00, 8'hA1},  // R5 bits moved back
        {1'b0, 4'd5,  16'hA002, 8'h00, 8'h33},  // R5 RAM page zeroed
        {1'b1, 4'd5,  16'h6000, 8'h02, 8'h00},
        {1'b0, 4'd5,  16'h4000, 8'h00, 8'hA1},  // R5 same mode no move
        {1'b1, 4'd1,  16'h0000, 8'h0B, 8'h00},
        {1'b0, 4'd1,  16'hA002, 8'h00, 8'hFF},  // R1 non-key closes
        {1'b1, 4'd12, 16'hA002, 8'h99, 8'h00},
        {1'b1, 4'd1,  16'h1FFF, 8'h0A, 8'h00},
        {1'b0, 4'd12, 16'hA002, 8'h00, 8'h33},  // R12 write was dropped
        {1'b0, 4'd13, 16'h8000, 8'h00, 8'hFF},  // R13
        {1'b0, 4'd13, 16'h9FFF, 8'h00, 8'hFF},  // R13
        {1'b0, 4'd13, 16'hC000, 8'h00, 8'hFF},  // R13
        {1'b0, 4'd13, 16'hFFFF, 8'h00, 8'hFF},  // R13
        {1'b1, 4'd13, 16'h8000, 8'h00, 8'h00},
        {1'b1, 4'd13, 16'hC000, 8'h00, 8'h00},
        {1'b0, 4'd13, 16'h4000, 8'h00, 8'hA1},  // R13 no state change
        {1'b0, 4'd13, 16'hA002, 8'h00, 8'h33},  // R13 gate still open
        {1'b1, 4'd4,  16'h4000, 8'h02, 8'h00},
        {1'b1, 4'd5,  16'h6000, 8'h01, 8'h00},
        {1'b0, 4'd10, 16'hA002, 8'h00, 8'h00},  // R10 RAM page 2 beyond count
        {1'b1, 4'd5,  16'h6000, 8'h03, 8'h00},
        {1'b0, 4'd5,  16'h4000, 8'h00, 8'h81},  // R5
        {1'b1, 4'd5,  16'h6000, 8'h00, 8'h00},
        {1'b0, 4'd10, 16'h4000, 8'h00, 8'h00},  // R10 page 0x41
        {1'b0, 4'd5,  16'hA002, 8'h00, 8'h33},  // R5
        {1'b1, 4'd2,  16'h2000, 8'h1F, 8'h00},
        {1'b1, 4'd2,  16'h4000, 8'h00, 8'h00},
        {1'b0, 4'd2,  16'h4000, 8'h00, 8'h9F},  // R2
        {1'b0, 4'd8,  16'h401F, 8'h00, 8'h80}   // R8
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a, input logic [7:0] exp, input int req);
        @(negedge clk);
        cpu_addr = a; cpu_wr = 1'b0; cpu_rd = 1'b1;
        #1;
        check(req, {24'h0, cpu_rdata}, {24'h0, exp});
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(2.0 * HALF * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) ram_mem[i] = 8'hEE;
        apply_reset();

        // R6: reset state at the ports
        @(negedge clk);
        cpu_addr = 16'h4000; cpu_rd = 1'b1;
        #1;
        check(6, {31'h0, rom_cs}, 32'h1);
        check(6, {11'h0, rom_addr}, 32'h0000_4000);
        @(negedge clk);
        cpu_addr = 16'hA000;
        #1;
        check(6, {31'h0, ram_cs}, 32'h0);
        check(6, {24'h0, cpu_rdata}, 32'hFF);
        @(negedge clk);
        cpu_rd = 1'b0;

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][36]) begin
                do_write(VEC[v][31:16], VEC[v][15:8]);
            end else begin
                do_read(VEC[v][31:16], VEC[v][7:0], int'(VEC[v][35:32]));
            end
        end

        // R10: write into a RAM page beyond the count is dropped
        do_write(16'h6000, 8'h01);
        do_write(16'h4000, 8'h03);
        @(negedge clk);
        cpu_addr = 16'hA000; cpu_wdata = 8'h77; cpu_wr = 1'b1;
        #1;
        check(10, {31'h0, ram_we}, 32'h0);
        check(10, {31'h0, ram_cs}, 32'h0);
        @(negedge clk);
        cpu_wr = 1'b0;

        // R9: write strobe and flat address in page 0
        do_write(16'h4000, 8'h00);
        @(negedge clk);
        cpu_addr = 16'hA004; cpu_wdata = 8'h42; cpu_wr = 1'b1;
        #1;
        check(9, {31'h0, ram_we}, 32'h1);
        check(9, {17'h0, ram_addr}, 32'h0000_0004);
        @(negedge clk);
        cpu_wr = 1'b0;
        do_read(16'hA004, 8'h42, 9);

        // R11: variant without RAM
        @(negedge clk);
        cpu_addr = 16'hA004; cpu_rd = 1'b1;
        #1;
        check(11, {24'h0, nr_rdata}, 32'h00);
        check(11, {31'h0, nr_ram_cs}, 32'h0);
        @(negedge clk);
        cpu_rd = 1'b0;

        // R6: reset in mid-run restores page 1, closed gate and ROM mode
        apply_reset();
        do_read(16'h4000, 8'h81, 6);
        do_read(16'hA002, 8'hFF, 6);
        do_write(16'h4000, 8'h01);
        do_read(16'h4000, 8'hA1, 6);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule